// File: doc/BRIEF.md
# Endpoint Control and Status Register

This block holds the control and status byte for one USB endpoint. It sits between a CPU register port and the serial interface engine. The CPU reads the byte, writes its control bits, and acknowledges the event flags by writing zero to them. The engine sends single-cycle strobes for the protocol events it sees, and it supplies the endpoint type. The type decides which strobes move which flag.

The block answers with the handshake the engine should send for the current token, a transmit-ready level, and an interrupt request that is gated by an enable input. It does not contain the packet storage or the serial engine.

Type encoding on `epType`: 0 = Control, 1 = Isochronous, 2 = Bulk, 3 = Interrupt.

Handshake encoding on `hsCode`: 0 = ACK, 1 = NAK, 2 = STALL, 3 = no handshake.

Register bits:

| Bit | Meaning |
|-----|---------|
| 7 | data direction |
| 6 | reserved |
| 5 | stall request |
| 4 | transmit armed |
| 3 | stall-sent flag (non-isochronous) or CRC-error flag (isochronous) |
| 2 | setup received |
| 1 | OUT received |
| 0 | IN complete |

Top module: `ep_status_ctrl`

## Requirements
- R1: After reset `cpuRdData` is 0x00. Bit 6 always reads 0, and writing 1 to bit 6 has no effect.
- R2: A CPU write loads bits 7, 5 and 4 with the written value. On flag bits 3..0 a written 0 clears the flag and a written 1 leaves it unchanged.
- R3: On the IN event that ends a transfer, bit 4 clears and bit 0 sets one cycle later. The ending event is `evInSent` for Isochronous and `evInAck` for every other type. The other IN strobe is ignored. A hardware clear of bit 4 wins over a CPU write of the same cycle.
- R4: When a hardware set and a CPU write-0 reach the same flag in the same cycle, the flag ends up set.
- R5: `evSetup` on a Control endpoint makes the byte read 0x04 one cycle later. This wins over any CPU write in the same cycle. On any other type `evSetup` is ignored.
- R6: `evOut` sets bit 1. On a non-isochronous endpoint with no stall request, an OUT token (`tokIn`=0) gets NAK while bit 1 is set.
- R7: On a non-isochronous endpoint `evStallSent` sets bit 3. On an Isochronous endpoint `evIsoCrcErr` sets bit 3, `evIsoGood` clears it, and `evStallSent` is ignored.
- R8: Isochronous endpoints always get `hsCode`=3. Otherwise the handshake is chosen in this order:
  - STALL when bit 5 is set;
  - NAK for an IN token when bit 4 is clear;
  - NAK for an OUT token when bit 1 is set;
  - ACK in all other cases.
- R9: `irq` is high exactly when `intEn` is high and any of bits 3..0 is set.
- R10: `txReady` equals bit 4 of the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | register read value |
| epType | input | 2 | endpoint type |
| tokIn | input | 1 | current token is IN (1) or OUT (0) |
| intEn | input | 1 | endpoint interrupt enable |
| evSetup | input | 1 | valid SETUP received |
| evOut | input | 1 | OUT packet received |
| evInSent | input | 1 | IN packet sent |
| evInAck | input | 1 | IN packet acknowledged by host |
| evStallSent | input | 1 | STALL handshake sent |
| evIsoGood | input | 1 | isochronous data received without error |
| evIsoCrcErr | input | 1 | isochronous data received with CRC error |
| hsCode | output | 2 | handshake to send |
| txReady | output | 1 | transmit armed |
| irq | output | 1 | endpoint interrupt request |

## Verification
The assertions assume that `epType` stays steady around the event strobes it qualifies. They also assume that the engine raises `evSetup` only on a Control endpoint when it expects the wipe to happen. The stimulus changes type only in cycles with no strobe active. Every strobe is held for exactly one clock and then dropped, so each vector's effect is observed before the next one is applied.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;
  localparam int REG_W     = 8;
  localparam int B_DIR     = 7;
  localparam int B_RSVD    = 6;
  localparam int B_STLREQ  = 5;
  localparam int B_TXRDY   = 4;
  localparam int B_STLCRC  = 3;
  localparam int B_SETUP   = 2;
  localparam int B_OUT     = 1;
  localparam int B_TXCMP   = 0;
  localparam int FLAG_N    = 4;

  localparam logic [1:0] EP_CTRL = 2'd0;
  localparam logic [1:0] EP_ISO  = 2'd1;
  localparam logic [1:0] EP_BULK = 2'd2;
  localparam logic [1:0] EP_INTR = 2'd3;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_NONE  = 2'd3
  } hs_e;

  typedef struct packed {
    logic             wipe;
    logic             cpuWr;
    logic [REG_W-1:0] wrData;
    logic             txDone;
    logic             setOut;
    logic             setStl;
    logic             clrStl;
  } strb_t;
endpackage

// File: rtl/ep_status_ctl.sv
module ep_status_ctl
  import ep_status_pkg::*;
(
  input  logic [1:0]       epType,
  input  logic             tokIn,
  input  logic             intEn,
  input  logic             cpuWrEn,
  input  logic [REG_W-1:0] cpuWrData,
  input  logic             evSetup,
  input  logic             evOut,
  input  logic             evInSent,
  input  logic             evInAck,
  input  logic             evStallSent,
  input  logic             evIsoGood,
  input  logic             evIsoCrcErr,
  input  logic [5:0]       state,
  output strb_t            strb,
  output logic [1:0]       hsCode,
  output logic             txReady,
  output logic             irq
);
  logic isIso;
  logic isCtrl;
  hs_e  hsSel;

  assign isIso  = (epType == EP_ISO);
  assign isCtrl = (epType == EP_CTRL);

  // Translate the engine strobes into register updates for this type.
  always_comb begin
    strb.wipe   = evSetup & isCtrl;
    strb.cpuWr  = cpuWrEn;
    strb.wrData = cpuWrData;
    strb.txDone = isIso ? evInSent : evInAck;
    strb.setOut = evOut;
    strb.setStl = isIso ? evIsoCrcErr : evStallSent;
    strb.clrStl = isIso & evIsoGood;
  end

  // Handshake selection, in priority order.
  always_comb begin
    if (isIso)
      hsSel = HS_NONE;
    else if (state[B_STLREQ])
      hsSel = HS_STALL;
    else if (tokIn ? !state[B_TXRDY] : state[B_OUT])
      hsSel = HS_NAK;
    else
      hsSel = HS_ACK;
  end

  assign hsCode  = hsSel;
  assign txReady = state[B_TXRDY];
  assign irq     = intEn & (|state[FLAG_N-1:0]);
endmodule

// File: rtl/ep_status_dp.sv
module ep_status_dp
  import ep_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  output logic [REG_W-1:0] regQ
);
  logic [REG_W-1:0] regD;

  always_comb begin
    regD = regQ;
    if (strb.wipe) begin
      regD          = '0;
      regD[B_SETUP] = 1'b1;
    end else begin
      if (strb.cpuWr) begin
        regD[B_DIR]        = strb.wrData[B_DIR];
        regD[B_STLREQ]     = strb.wrData[B_STLREQ];
        regD[B_TXRDY]      = strb.wrData[B_TXRDY];
        regD[FLAG_N-1:0]   = regQ[FLAG_N-1:0] & strb.wrData[FLAG_N-1:0];
      end
      // Hardware updates are applied last, so they win over CPU writes.
      if (strb.txDone) begin
        regD[B_TXRDY] = 1'b0;
        regD[B_TXCMP] = 1'b1;
      end
      if (strb.setOut) regD[B_OUT]    = 1'b1;
      if (strb.clrStl) regD[B_STLCRC] = 1'b0;
      if (strb.setStl) regD[B_STLCRC] = 1'b1;
    end
    regD[B_RSVD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regD;
  end
endmodule

// File: rtl/ep_status_ctrl.sv
module ep_status_ctrl
  import ep_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrEn,
  input  logic [7:0] cpuWrData,
  output logic [7:0] cpuRdData,
  input  logic [1:0] epType,
  input  logic       tokIn,
  input  logic       intEn,
  input  logic       evSetup,
  input  logic       evOut,
  input  logic       evInSent,
  input  logic       evInAck,
  input  logic       evStallSent,
  input  logic       evIsoGood,
  input  logic       evIsoCrcErr,
  output logic [1:0] hsCode,
  output logic       txReady,
  output logic       irq
);
  strb_t            strb;
  logic [REG_W-1:0] regQ;

  ep_status_ctl u_ctl (
    .epType     (epType),
    .tokIn      (tokIn),
    .intEn      (intEn),
    .cpuWrEn    (cpuWrEn),
    .cpuWrData  (cpuWrData),
    .evSetup    (evSetup),
    .evOut      (evOut),
    .evInSent   (evInSent),
    .evInAck    (evInAck),
    .evStallSent(evStallSent),
    .evIsoGood  (evIsoGood),
    .evIsoCrcErr(evIsoCrcErr),
    .state      (regQ[5:0]),
    .strb       (strb),
    .hsCode     (hsCode),
    .txReady    (txReady),
    .irq        (irq)
  );

  ep_status_dp u_dp (
    .clk (clk),
    .rstN(rstN),
    .strb(strb),
    .regQ(regQ)
  );

  assign cpuRdData = regQ;
endmodule

// File: rtl/ep_status_chk.sv
module ep_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuWrEn,
  input logic [7:0] cpuRdData,
  input logic [1:0] epType,
  input logic       tokIn,
  input logic       intEn,
  input logic       evSetup,
  input logic       evOut,
  input logic       evInAck,
  input logic       evStallSent,
  input logic       evIsoCrcErr,
  input logic [1:0] hsCode,
  input logic       txReady,
  input logic       irq
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdData[6] == 1'b0);

  // R5
  setup_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evSetup && epType == 2'd0) |=> (cpuRdData == 8'h04));

  // R3
  ack_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evInAck && epType != 2'd1 && !evSetup) |=> (!txReady && cpuRdData[0]));

  // R4
  out_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evOut && cpuWrEn && !(evSetup && epType == 2'd0)) |=> cpuRdData[1]);

  // R7
  stall_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evStallSent && epType != 2'd1) || (evIsoCrcErr && epType == 2'd1))
      && !(evSetup && epType == 2'd0) |=> cpuRdData[3]);

  // R6
  out_nak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdData[1] && !tokIn && epType != 2'd1 && !cpuRdData[5]) |-> (hsCode == 2'd1));

  // R8
  iso_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (epType == 2'd1) |-> (hsCode == 2'd3));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !irq);
endmodule

bind ep_status_ctrl ep_status_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuWrEn    (cpuWrEn),
  .cpuRdData  (cpuRdData),
  .epType     (epType),
  .tokIn      (tokIn),
  .intEn      (intEn),
  .evSetup    (evSetup),
  .evOut      (evOut),
  .evInAck    (evInAck),
  .evStallSent(evStallSent),
  .evIsoCrcErr(evIsoCrcErr),
  .hsCode     (hsCode),
  .txReady    (txReady),
  .irq        (irq)
);

// File: tb/tb_ep_status_ctrl.sv
module tb_ep_status_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuWrEn = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic [1:0] epType = 2'd2;
  logic       tokIn = 1'b0;
  logic       intEn = 1'b1;
  logic       evSetup = 1'b0, evOut = 1'b0, evInSent = 1'b0, evInAck = 1'b0;
  logic       evStallSent = 1'b0, evIsoGood = 1'b0, evIsoCrcErr = 1'b0;
  logic [1:0] hsCode;
  logic       txReady;
  logic       irq;
  int         nVec = 0;
  int         nBad = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  ep_status_ctrl dut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .epType(epType), .tokIn(tokIn), .intEn(intEn),
    .evSetup(evSetup), .evOut(evOut), .evInSent(evInSent), .evInAck(evInAck),
    .evStallSent(evStallSent), .evIsoGood(evIsoGood), .evIsoCrcErr(evIsoCrcErr),
    .hsCode(hsCode), .txReady(txReady), .irq(irq)
  );

  // Fields: req[4] type[2] wr[1] data[8] ev[7] tok[1] ie[1] expRd[8] expHs[2] expIrq[1]
  // Event order: setup, out, inSent, inAck, stallSent, isoGood, isoCrc
  localparam int NV = 22;
  localparam logic [34:0] VEC [NV] = '{
    {4'd2,  2'd2, 1'b1, 8'h10, 7'b0000000, 1'b1, 1'b1, 8'h10, 2'd0, 1'b0}, // R2 arm
    {4'd3,  2'd2, 1'b0, 8'h00, 7'b0010000, 1'b1, 1'b1, 8'h10, 2'd0, 1'b0}, // R3 sent ignored
    {4'd3,  2'd2, 1'b0, 8'h00, 7'b0001000, 1'b1, 1'b1, 8'h01, 2'd1, 1'b1}, // R3 ack
    {4'd2,  2'd2, 1'b1, 8'h00, 7'b0000000, 1'b1, 1'b1, 8'h00, 2'd1, 1'b0}, // R2 clear
    {4'd6,  2'd2, 1'b0, 8'h00, 7'b0100000, 1'b0, 1'b1, 8'h02, 2'd1, 1'b1}, // R6
    {4'd1,  2'd2, 1'b1, 8'hFF, 7'b0000000, 1'b0, 1'b1, 8'hB2, 2'd2, 1'b1}, // R1 rsvd
    {4'd7,  2'd2, 1'b0, 8'h00, 7'b0000100, 1'b0, 1'b1, 8'hBA, 2'd2, 1'b1}, // R7
    {4'd4,  2'd2, 1'b1, 8'h00, 7'b0100000, 1'b0, 1'b1, 8'h02, 2'd1, 1'b1}, // R4
    {4'd8,  2'd2, 1'b1, 8'h10, 7'b0000000, 1'b1, 1'b1, 8'h10, 2'd0, 1'b0}, // R8 ack
    {4'd3,  2'd1, 1'b0, 8'h00, 7'b0010000, 1'b1, 1'b1, 8'h01, 2'd3, 1'b1}, // R3 iso
    {4'd10, 2'd1, 1'b1, 8'h10, 7'b0000000, 1'b1, 1'b1, 8'h10, 2'd3, 1'b0}, // R10
    {4'd3,  2'd1, 1'b0, 8'h00, 7'b0001000, 1'b1, 1'b1, 8'h10, 2'd3, 1'b0}, // R3 ack ignored
    {4'd7,  2'd1, 1'b0, 8'h00, 7'b0000001, 1'b1, 1'b1, 8'h18, 2'd3, 1'b1}, // R7 crc
    {4'd7,  2'd1, 1'b0, 8'h00, 7'b0000010, 1'b1, 1'b1, 8'h10, 2'd3, 1'b0}, // R7 good
    {4'd7,  2'd1, 1'b0, 8'h00, 7'b0000100, 1'b1, 1'b1, 8'h10, 2'd3, 1'b0}, // R7 stall ignored
    {4'd5,  2'd1, 1'b0, 8'h00, 7'b1000000, 1'b1, 1'b1, 8'h10, 2'd3, 1'b0}, // R5 not ctrl
    {4'd8,  2'd0, 1'b1, 8'hB0, 7'b0000000, 1'b1, 1'b1, 8'hB0, 2'd2, 1'b0}, // R8 stall
    {4'd5,  2'd0, 1'b1, 8'h00, 7'b1000000, 1'b1, 1'b1, 8'h04, 2'd1, 1'b1}, // R5 wipe
    {4'd9,  2'd0, 1'b0, 8'h00, 7'b0000000, 1'b1, 1'b0, 8'h04, 2'd1, 1'b0}, // R9
    {4'd2,  2'd0, 1'b1, 8'h00, 7'b0000000, 1'b1, 1'b1, 8'h00, 2'd1, 1'b0}, // R2
    {4'd6,  2'd0, 1'b0, 8'h00, 7'b0100000, 1'b0, 1'b1, 8'h02, 2'd1, 1'b1}, // R6
    {4'd5,  2'd0, 1'b0, 8'h00, 7'b1000000, 1'b0, 1'b1, 8'h04, 2'd0, 1'b1}  // R5 over OUT
  };

  task automatic check(input int req, input logic [7:0] eRd,
                       input logic [1:0] eHs, input logic eIrq);
    nVec++;
    if (cpuRdData !== eRd || hsCode !== eHs || irq !== eIrq || txReady !== eRd[4]) begin
      nBad++;
      $display("FAIL R%0d: rd=%h hs=%0d irq=%b txr=%b expected rd=%h hs=%0d irq=%b txr=%b",
               req, cpuRdData, hsCode, irq, txReady, eRd, eHs, eIrq, eRd[4]);
    end
  endtask

  initial begin
    #20000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 8'h00, 2'd0, 1'b0); // R1 reset state
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      epType = VEC[i][30:29];
      cpuWrEn = VEC[i][28];
      cpuWrData = VEC[i][27:20];
      {evSetup, evOut, evInSent, evInAck, evStallSent, evIsoGood, evIsoCrcErr} = VEC[i][19:13];
      tokIn = VEC[i][12];
      intEn = VEC[i][11];
      @(posedge clk); #2;
      cpuWrEn = 1'b0;
      {evSetup, evOut, evInSent, evInAck, evStallSent, evIsoGood, evIsoCrcErr} = '0;
      #1;
      check(int'(VEC[i][34:31]), VEC[i][10:3], VEC[i][2:1], VEC[i][0]);
    end
    // R1: reset in mid-run returns to zero
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    epType = 2'd3; tokIn = 1'b0;
    #1;
    check(1, 8'h00, 2'd0, 1'b0);
    // R8: IN token on interrupt endpoint, not armed, gets NAK
    tokIn = 1'b1; #1;
    check(8, 8'h00, 2'd1, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule